// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block turns single register requests into complete bus cycles for a peripheral that shares one 8-bit bus for both address and data. The peripheral is driven through these strobes:

- an address latch strobe;
- an active-low select;
- separate active-low read and write strobes;
- a buffer direction line.

The requester presents an address, a write byte and a write flag for one clock while the block is not busy. The block then works through a fixed series of phases. Each phase holds for a parameterised number of clocks. The block answers with a one-clock completion pulse and, for reads, the byte it captured.

The peripheral sees every byte bit-reversed, with bit 0 and bit 7 exchanged and so on inward. This applies in both directions, for the address as well as the data.

A cycle starts by pulling the select low while the latch strobe is still high. The address is then placed on the bus, and the latch strobe drops to capture it.

- **Write:** the data byte replaces the address, and the write strobe pulses low.
- **Read:** the block stops driving the bus and turns the buffer direction around. It then pulses the read strobe and turns the direction back.

Both kinds of cycle end with the select returning high.

Top module: `mux_bus_cycle_gen`

## Requirements
- R1: Out of reset and whenever no cycle is running, selN, latch, rdN, wrN and dirN are all 1, busOe is 0, and busy and done are 0.
- R2: A request (reqValid=1) sampled on a clock edge while busy is 0 starts a cycle. busy is 1 from the next clock until the cycle ends.
- R3: A request sampled while busy is 1 is ignored: no further cycle follows the current one.
- R4: Every cycle begins with these phases, in order:
  - select low with latch high and the bus undriven;
  - select low with latch high and the reversed address driven;
  - latch low with the reversed address still driven.
- R5: A write cycle then passes through these phases:
  - the reversed data byte driven;
  - the same byte with wrN low;
  - the same byte with wrN high.
  
  A final phase follows with selN high, latch low and the bus undriven.
- R6: A read cycle then passes through these phases:
  - bus undriven with dirN low;
  - rdN low with dirN low;
  - rdN high with dirN low;
  - dirN high.
  
  The same final phase as a write follows. rdN is never low while the bus is driven or dirN is high.
- R7: rdData presents the reversed value of busIn sampled on the clock edge that ends the rdN-low phase. It holds that value until the next read capture.
- R8: Every phase, including each strobe-low phase, lasts exactly STEP_CYCLES clocks.
- R9: done is a single-clock pulse in the clock right after the final phase. In that clock busy is already 0 and a new request is accepted.
- R10: rdN and wrN are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is 0 |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqAddr | input | DATA_W | Register address |
| reqWdata | input | DATA_W | Byte to write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Last captured read byte, bit-reversed back |
| busOut | output | DATA_W | Bus value driven toward the peripheral |
| busOe | output | 1 | Bus output enable |
| busIn | input | DATA_W | Bus value from the peripheral |
| selN | output | 1 | Active-low peripheral select |
| latch | output | 1 | Address latch strobe, address taken on its fall |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| dirN | output | 1 | Buffer direction, 1 = toward peripheral |

## Verification
The hardest situations to reach from the ports involve a single clock edge each:

- **Read capture.** It happens on exactly one edge. Here the bench changes busIn on every clock, so only the value present at the end of the rdN-low phase can match.
- **Acceptance in the done clock.** The bench waits until only the completion clock remains in its model and then issues the next request in that clock. This drives back-to-back cycles.
- **Rejection while busy.** A request is dropped into the middle of a write cycle. The per-clock comparison then shows that no extra cycle appears.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SEL,
    PH_ADDR,
    PH_LATCH,
    PH_WDATA,
    PH_WSTB,
    PH_WREL,
    PH_TURN,
    PH_RSTB,
    PH_RREL,
    PH_RESTORE,
    PH_END
  } phase_e;

  typedef struct packed {
    logic load;      // capture request fields
    logic selN;
    logic latch;
    logic drvAddr;
    logic drvData;
    logic dirN;
    logic rdN;
    logic wrN;
    logic capture;   // sample busIn on this edge
  } busCtl_t;

endpackage

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
#(
  parameter int STEP_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    busy,
  output logic    done,
  output busCtl_t ctl
);

  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEP_CYCLES - 1);

  phase_e           phase, nextPhase;
  logic [CNT_W-1:0] stepCnt;
  logic             isWrite;
  logic             doneQ;
  logic             accept;
  logic             phaseEnd;

  assign accept   = reqValid && (phase == PH_IDLE);
  assign phaseEnd = (stepCnt == LAST_STEP);

  always_comb begin
    nextPhase = phase;
    case (phase)
      PH_SEL:     nextPhase = PH_ADDR;
      PH_ADDR:    nextPhase = PH_LATCH;
      PH_LATCH:   nextPhase = isWrite ? PH_WDATA : PH_TURN;
      PH_WDATA:   nextPhase = PH_WSTB;
      PH_WSTB:    nextPhase = PH_WREL;
      PH_WREL:    nextPhase = PH_END;
      PH_TURN:    nextPhase = PH_RSTB;
      PH_RSTB:    nextPhase = PH_RREL;
      PH_RREL:    nextPhase = PH_RESTORE;
      PH_RESTORE: nextPhase = PH_END;
      PH_END:     nextPhase = PH_IDLE;
      default:    nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepCnt <= '0;
      isWrite <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        phase   <= PH_SEL;
        stepCnt <= '0;
        isWrite <= reqWrite;
      end else if (phase != PH_IDLE) begin
        if (phaseEnd) begin
          phase   <= nextPhase;
          stepCnt <= '0;
          if (phase == PH_END) doneQ <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = accept;
    ctl.selN    = 1'b0;
    ctl.latch   = 1'b0;
    ctl.dirN    = 1'b1;
    ctl.rdN     = 1'b1;
    ctl.wrN     = 1'b1;
    case (phase)
      PH_IDLE: begin
        ctl.selN  = 1'b1;
        ctl.latch = 1'b1;
      end
      PH_SEL:   ctl.latch = 1'b1;
      PH_ADDR: begin
        ctl.latch   = 1'b1;
        ctl.drvAddr = 1'b1;
      end
      PH_LATCH: ctl.drvAddr = 1'b1;
      PH_WDATA: ctl.drvData = 1'b1;
      PH_WSTB: begin
        ctl.drvData = 1'b1;
        ctl.wrN     = 1'b0;
      end
      PH_WREL:  ctl.drvData = 1'b1;
      PH_TURN:  ctl.dirN = 1'b0;
      PH_RSTB: begin
        ctl.dirN    = 1'b0;
        ctl.rdN     = 1'b0;
        ctl.capture = phaseEnd;
      end
      PH_RREL:  ctl.dirN = 1'b0;
      PH_END:   ctl.selN = 1'b1;
      default: ;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign done = doneQ;

  // R9: completion pulse lasts one clock
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: an accepted request makes the block busy on the next clock
  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R3: busy only starts from a request seen while idle
  p_start_from_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R10: strobes exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!ctl.rdN && !ctl.wrN));

  // R4: address latch falls only while selected
  p_latch_fall_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.latch) |-> !ctl.selN);

endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] addrRev, dataRev, inRev;
  logic [DATA_W-1:0] addrQ, dataQ, rdQ;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign addrRev[i] = reqAddr[DATA_W-1-i];
    assign dataRev[i] = reqWdata[DATA_W-1-i];
    assign inRev[i]   = busIn[DATA_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      rdQ   <= '0;
    end else begin
      if (ctl.load) begin
        addrQ <= addrRev;
        dataQ <= dataRev;
      end
      if (ctl.capture) rdQ <= inRev;
    end
  end

  always_comb begin
    busOut = '0;
    if (ctl.drvAddr)      busOut = addrQ;
    else if (ctl.drvData) busOut = dataQ;
  end

  assign busOe  = ctl.drvAddr | ctl.drvData;
  assign rdData = rdQ;

  // R7: read result changes only on the capture edge
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(rdData));

endmodule

// File: rtl/mux_bus_cycle_gen.sv
module mux_bus_cycle_gen
  import mbc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STEP_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] busIn,
  output logic              selN,
  output logic              latch,
  output logic              rdN,
  output logic              wrN,
  output logic              dirN
);

  busCtl_t ctl;

  mbc_ctrl #(.STEP_CYCLES(STEP_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busy     (busy),
    .done     (done),
    .ctl      (ctl)
  );

  mbc_datapath #(.DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busIn    (busIn),
    .busOut   (busOut),
    .busOe    (busOe),
    .rdData   (rdData)
  );

  assign selN  = ctl.selN;
  assign latch = ctl.latch;
  assign rdN   = ctl.rdN;
  assign wrN   = ctl.wrN;
  assign dirN  = ctl.dirN;

  // R6: read strobe only with the bus released and direction turned
  p_rd_turned_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!dirN && !busOe));

  // R1: idle leaves every strobe high
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (selN && latch && rdN && wrN && dirN && !busOe));

endmodule

// File: tb/tb_mux_bus_cycle_gen.sv
module tb_mux_bus_cycle_gen;

  localparam int STEP = 3;

  typedef struct packed {
    logic       selN, latch, rdN, wrN, dirN, oe;
    logic [7:0] bus;
    logic       busy, done, cap, isRd;
  } vec_t;

  logic       clk = 0, rstN = 0;
  logic       reqValid = 0, reqWrite = 0;
  logic [7:0] reqAddr = 0, reqWdata = 0, busIn = 0;
  logic       busy, done, busOe, selN, latch, rdN, wrN, dirN;
  logic [7:0] rdData, busOut;

  int checks = 0, failures = 0;
  int wrLow = 0, rdLow = 0;
  logic [7:0] expRd = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;
  vec_t q[$];

  always #4 clk = ~clk;

  mux_bus_cycle_gen #(.DATA_W(8), .STEP_CYCLES(STEP)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdData(rdData), .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .selN(selN), .latch(latch), .rdN(rdN), .wrN(wrN), .dirN(dirN));

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic vec_t mk(input logic s, l, r, w, dr, oe,
                              input logic [7:0] b, input logic bz);
    vec_t v;
    v = '0;
    v.selN = s; v.latch = l; v.rdN = r; v.wrN = w; v.dirN = dr;
    v.oe = oe; v.bus = b; v.busy = bz;
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pushPhase(input vec_t v, input logic capLast);
    for (int s = 0; s < STEP; s++) begin
      vec_t t;
      t = v;
      t.cap = capLast && (s == STEP - 1);
      q.push_back(t);
    end
  endtask

  task automatic pushSeq(input logic w, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] ma, md;
    vec_t fin;
    ma = rev8(a);
    md = rev8(d);
    pushPhase(mk(0, 1, 1, 1, 1, 0, 8'h00, 1), 0);   // R4 select
    pushPhase(mk(0, 1, 1, 1, 1, 1, ma, 1), 0);      // R4 address
    pushPhase(mk(0, 0, 1, 1, 1, 1, ma, 1), 0);      // R4 latch fall
    if (w) begin
      pushPhase(mk(0, 0, 1, 1, 1, 1, md, 1), 0);    // R5 data
      pushPhase(mk(0, 0, 1, 0, 1, 1, md, 1), 0);    // R5 strobe
      pushPhase(mk(0, 0, 1, 1, 1, 1, md, 1), 0);    // R5 release
    end else begin
      pushPhase(mk(0, 0, 1, 1, 0, 0, 8'h00, 1), 0); // R6 turn
      pushPhase(mk(0, 0, 0, 1, 0, 0, 8'h00, 1), 1); // R6 strobe, R7 capture
      pushPhase(mk(0, 0, 1, 1, 0, 0, 8'h00, 1), 0); // R6 release
      pushPhase(mk(0, 0, 1, 1, 1, 0, 8'h00, 1), 0); // R6 restore
    end
    pushPhase(mk(1, 0, 1, 1, 1, 0, 8'h00, 1), 0);   // final phase
    fin = mk(1, 1, 1, 1, 1, 0, 8'h00, 0);
    fin.done = 1;
    fin.isRd = !w;
    q.push_back(fin);                               // R9 completion clock
  endtask

  task automatic tick(input logic v, input logic w, input logic [7:0] a, input logic [7:0] d);
    vec_t e;
    string tg;
    @(negedge clk);
    e = (q.size() > 0) ? q.pop_front() : mk(1, 1, 1, 1, 1, 0, 8'h00, 0);
    tg = (!e.busy && !e.done) ? "R1" : "";
    if (!wrN) wrLow++;
    if (!rdN) rdLow++;
    chk(selN == e.selN,   (tg != "") ? tg : "R4 selN", selN, e.selN);
    chk(latch == e.latch, (tg != "") ? tg : "R4 latch", latch, e.latch);
    chk(wrN == e.wrN,     (tg != "") ? tg : "R5 wrN", wrN, e.wrN);
    chk(rdN == e.rdN,     (tg != "") ? tg : "R6 rdN", rdN, e.rdN);
    chk(dirN == e.dirN,   (tg != "") ? tg : "R6 dirN", dirN, e.dirN);
    chk(busOe == e.oe,    (tg != "") ? tg : "R6 busOe", busOe, e.oe);
    if (e.oe) chk(busOut == e.bus, "R4 R5 busOut", busOut, e.bus);
    chk(busy == e.busy, "R2 busy", busy, e.busy);
    chk(done == e.done, "R9 done", done, e.done);
    chk(!(!rdN && !wrN), "R10 strobes", {rdN, wrN}, 2'b11);
    if (e.done) begin
      if (e.isRd) begin
        chk(rdData == expRd, "R7 rdData", rdData, expRd);
        chk(rdLow == STEP, "R8 rdN low length", rdLow, STEP);
      end else begin
        chk(wrLow == STEP, "R8 wrN low length", wrLow, STEP);
      end
      wrLow = 0;
      rdLow = 0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busIn = lfsr[7:0];
    if (e.cap) expRd = rev8(busIn);
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    if (v && !e.busy) pushSeq(w, a, d);
  endtask

  task automatic drain();
    while (q.size() > 0) tick(0, 0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    repeat (3) tick(0, 0, 8'h00, 8'h00);
    chk(rdData == 8'h00, "R1 rdData reset", rdData, 0);
    tick(1, 1, 8'h01, 8'hA5); drain();
    tick(0, 0, 8'h00, 8'h00);
    tick(1, 0, 8'h3C, 8'h00); drain();
    tick(1, 1, 8'h80, 8'h00); drain();
    tick(1, 0, 8'hFF, 8'h00); drain();
    // R3 request while busy must be ignored
    tick(1, 1, 8'h12, 8'h34);
    repeat (5) tick(1, 0, 8'h55, 8'hAA);
    tick(0, 0, 8'h00, 8'h00);
    drain();
    repeat (2) tick(0, 0, 8'h00, 8'h00);
    chk(busy == 0, "R3 no extra cycle", busy, 0);
    // R9 back-to-back: request in the done clock
    tick(1, 0, 8'h0F, 8'h00);
    while (q.size() > 1) tick(0, 0, 8'h00, 8'h00);
    tick(1, 1, 8'hF0, 8'h81);
    while (q.size() > 1) tick(0, 0, 8'h00, 8'h00);
    tick(1, 0, 8'hC3, 8'h00);
    drain();
    repeat (3) tick(0, 0, 8'h00, 8'h00);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule